// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches a stream of bus write cycles aimed at a byte-wide parallel NOR flash. Each cycle is one address and one data byte, marked by a single-cycle strobe. The block recognises the command sequences that begin with the two-write unlock key. For each command it finds, it raises a one-cycle pulse. Byte program and sector erase pulses come with their address and data payload. The block also keeps the flag that tells the read path whether identification mode is active.

A write whose address or data does not fit the sequence drops the decoder back to idle without a command. While the array is busy, an external input holds the decoder at idle and it ignores every write. All outputs are registered. A command pulse appears in the clock cycle after the strobe of its final write.

Top module: `fcmd_decoder`

## Requirements
- R1: A synchronous active-low reset clears the sequence state and `id_mode`. In the cycle after reset is released, no command pulse is high.
- R2: The unlock key is data AAh at the first key address 5555h, then data 55h at the second key address 2AAAh. Only address bits [14:0] are compared, so higher address bits never affect a match. Cycles without `wr_stb` are not writes.
- R3: Key, then A0h at 5555h, then one more write produces `prog_pulse` in the cycle after that write's strobe. `prog_addr` and `prog_data` carry that write's address and data.
- R4: Key, then 90h at 5555h produces `id_enter_pulse`. `id_mode` is 1 from that same cycle onward.
- R5: Key, then F0h at 5555h produces `id_exit_pulse` and clears `id_mode`. So does one F0h write to any address while the decoder is idle.
- R6: Key, 80h at 5555h, the key again, then 10h at 5555h produces `chip_erase_pulse`.
- R7: The same six-write form ending in 30h at any address produces `sect_erase_pulse`. `sect_addr` holds that last write's full address.
- R8: The same six-write form ending in 40h at 5555h produces `boot_lock_pulse`.
- R9: A write that does not match the expected address and data at any point returns the decoder to idle with no pulse. That write does not itself begin a new key and does not count as the lone F0h exit.
- R10: While `busy` is high, writes are ignored and the sequence state is forced to idle. No command pulse follows a cycle in which `busy` was high.
- R11: At most one command pulse is high in any cycle, and each command yields exactly one pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Array operation in progress; writes ignored |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| prog_pulse | output | 1 | Byte program command |
| prog_addr | output | ADDR_W | Target address of the last program command |
| prog_data | output | 8 | Data of the last program command |
| chip_erase_pulse | output | 1 | Whole-array erase command |
| sect_erase_pulse | output | 1 | Sector erase command |
| sect_addr | output | ADDR_W | Address given with the last sector erase |
| boot_lock_pulse | output | 1 | Boot-block lockout enable command |
| id_enter_pulse | output | 1 | Identification mode entry |
| id_exit_pulse | output | 1 | Identification mode exit |
| id_mode | output | 1 | Identification mode active |

## Verification
The bench builds the decoder with `ADDR_W` = 20 rather than the default 17. This leaves five address bits above the compared field. Key writes can then carry arbitrary upper bits, and the bench can show that only bits [14:0] decide a match. The wider bus also lets the program and sector erase payloads be checked across their full 20-bit width.

// File: rtl/fcmd_pkg.sv
// Package: shared codes, state encoding and cycle classification types for
// the flash command sequence decoder. Assumes an 8-bit data bus and a
// 15-bit compared address field.
package fcmd_pkg;

    localparam int CMP_W  = 15;
    localparam int DATA_W = 8;

    localparam logic [CMP_W-1:0]  ADR_KEY_A = 15'h5555;
    localparam logic [CMP_W-1:0]  ADR_KEY_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_A     = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_B     = 8'h55;
    localparam logic [DATA_W-1:0] OP_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ID_IN  = 8'h90;
    localparam logic [DATA_W-1:0] OP_ID_OUT = 8'hF0;
    localparam logic [DATA_W-1:0] OP_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] OP_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] OP_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] OP_LOCK   = 8'h40;

    localparam int NUM_CODES = 9;

    // Index order of the data code comparators built by the classifier.
    localparam int IX_KEY_A = 0;
    localparam int IX_KEY_B = 1;
    localparam int IX_PROG  = 2;
    localparam int IX_IDIN  = 3;
    localparam int IX_IDOUT = 4;
    localparam int IX_ERASE = 5;
    localparam int IX_CHIP  = 6;
    localparam int IX_SECT  = 7;
    localparam int IX_LOCK  = 8;

    // Return the data code compared by comparator slot idx.
    function automatic logic [DATA_W-1:0] code_of(input int idx);
        case (idx)
            IX_KEY_A: code_of = KEY_A;
            IX_KEY_B: code_of = KEY_B;
            IX_PROG:  code_of = OP_PROG;
            IX_IDIN:  code_of = OP_ID_IN;
            IX_IDOUT: code_of = OP_ID_OUT;
            IX_ERASE: code_of = OP_ERASE;
            IX_CHIP:  code_of = OP_CHIP;
            IX_SECT:  code_of = OP_SECT;
            default:  code_of = OP_LOCK;
        endcase
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_KEY1 = 3'd1,
        ST_KEY2 = 3'd2,
        ST_PROG = 3'd3,
        ST_ERA0 = 3'd4,
        ST_ERA1 = 3'd5,
        ST_ERA2 = 3'd6
    } seq_state_t;

    // What one write cycle could mean, independent of sequence position.
    typedef struct packed {
        logic key_a;      // AAh at first key address
        logic key_b;      // 55h at second key address
        logic prog;       // A0h at first key address
        logic id_in;      // 90h at first key address
        logic id_out_key; // F0h at first key address
        logic id_out_any; // F0h at any address
        logic erase;      // 80h at first key address
        logic chip;       // 10h at first key address
        logic sect;       // 30h at any address
        logic lock;       // 40h at first key address
    } cyc_class_t;

    // Commands decoded in the current cycle, one bit each.
    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic lock;
        logic id_in;
        logic id_out;
    } cmd_t;

endpackage

// File: rtl/fcmd_classify.sv
// Module: fcmd_classify
// Purely combinational. Classifies one write cycle by comparing the low
// address field and the data byte against the command constants.
// Assumes the caller passes only the compared address bits.
module fcmd_classify
    import fcmd_pkg::*;
(
    input  logic [CMP_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] data,
    output cyc_class_t        cls
);

    logic at_a;
    logic at_b;
    logic [NUM_CODES-1:0] hit;

    // Address field comparison against the two key locations.
    always_comb begin
        at_a = (addr_lo == ADR_KEY_A);
        at_b = (addr_lo == ADR_KEY_B);
    end

    // One data comparator per command code.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign hit[i] = (data == code_of(i));
    end

    // Combine data hits with the address each code requires.
    always_comb begin
        cls.key_a      = hit[IX_KEY_A] & at_a;
        cls.key_b      = hit[IX_KEY_B] & at_b;
        cls.prog       = hit[IX_PROG]  & at_a;
        cls.id_in      = hit[IX_IDIN]  & at_a;
        cls.id_out_key = hit[IX_IDOUT] & at_a;
        cls.id_out_any = hit[IX_IDOUT];
        cls.erase      = hit[IX_ERASE] & at_a;
        cls.chip       = hit[IX_CHIP]  & at_a;
        cls.sect       = hit[IX_SECT];
        cls.lock       = hit[IX_LOCK]  & at_a;
    end

endmodule

// File: rtl/fcmd_seq.sv
// Module: fcmd_seq
// Sequence state machine. Walks the unlock key and the command byte, emits
// a combinational command strobe in the cycle of the final write, and falls
// back to idle on any mismatch. Busy forces idle. Assumes cls is valid
// whenever wr_stb is high.
module fcmd_seq
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       wr_stb,
    input  cyc_class_t cls,
    output cmd_t       cmd
);

    seq_state_t state;
    seq_state_t state_nx;
    logic       take;

    // A write counts only when strobed and the array is not busy.
    always_comb take = wr_stb & ~busy;

    // Next state and command strobe decode.
    always_comb begin
        state_nx = state;
        cmd      = '0;
        if (busy) begin
            state_nx = ST_IDLE;
        end else if (take) begin
            state_nx = ST_IDLE;
            case (state)
                ST_IDLE: begin
                    if (cls.key_a)           state_nx   = ST_KEY1;
                    else if (cls.id_out_any) cmd.id_out = 1'b1;
                end
                ST_KEY1: if (cls.key_b) state_nx = ST_KEY2;
                ST_KEY2: begin
                    if (cls.prog)            state_nx   = ST_PROG;
                    else if (cls.erase)      state_nx   = ST_ERA0;
                    else if (cls.id_in)      cmd.id_in  = 1'b1;
                    else if (cls.id_out_key) cmd.id_out = 1'b1;
                end
                ST_PROG: cmd.prog = 1'b1;
                ST_ERA0: if (cls.key_a) state_nx = ST_ERA1;
                ST_ERA1: if (cls.key_b) state_nx = ST_ERA2;
                ST_ERA2: begin
                    if (cls.chip)      cmd.chip = 1'b1;
                    else if (cls.lock) cmd.lock = 1'b1;
                    else if (cls.sect) cmd.sect = 1'b1;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R10: a busy cycle leaves the sequence at idle.
    a_r10_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> state == ST_IDLE);

    // R3: the program state is left on the very next write.
    a_r3_prog_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PROG && $past(wr_stb)) |-> state != ST_PROG);

endmodule

// File: rtl/fcmd_idmode.sv
// Module: fcmd_idmode
// Holds the identification-mode flag. Set by an entry strobe, cleared by an
// exit strobe or reset. Assumes set and clear are never high together.
module fcmd_idmode (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic id_mode
);

    // Flag register with exit taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)     id_mode <= 1'b0;
        else if (clr_i) id_mode <= 1'b0;
        else if (set_i) id_mode <= 1'b1;
    end

    // R4: the flag only rises on an entry strobe.
    a_r4_set_only_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(set_i));

    // R5: outside reset the flag only falls on an exit strobe.
    a_r5_clear_only_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(id_mode) && $past(rst_n)) |-> $past(clr_i));

endmodule

// File: rtl/fcmd_decoder.sv
// Module: fcmd_decoder (top)
// Decodes unlock-prefixed flash command sequences from a strobed write
// stream into registered one-cycle command pulses with payload, and keeps
// the identification-mode flag. Assumes ADDR_W >= 15 and that wr_addr and
// wr_data are valid whenever wr_stb is high.
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              prog_pulse,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              chip_erase_pulse,
    output logic              sect_erase_pulse,
    output logic [ADDR_W-1:0] sect_addr,
    output logic              boot_lock_pulse,
    output logic              id_enter_pulse,
    output logic              id_exit_pulse,
    output logic              id_mode
);

    cyc_class_t cls;
    cmd_t       cmd;

    fcmd_classify u_cls (
        .addr_lo (wr_addr[CMP_W-1:0]),
        .data    (wr_data),
        .cls     (cls)
    );

    fcmd_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .wr_stb (wr_stb),
        .cls    (cls),
        .cmd    (cmd)
    );

    fcmd_idmode u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cmd.id_in),
        .clr_i   (cmd.id_out),
        .id_mode (id_mode)
    );

    // Command pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_pulse       <= 1'b0;
            chip_erase_pulse <= 1'b0;
            sect_erase_pulse <= 1'b0;
            boot_lock_pulse  <= 1'b0;
            id_enter_pulse   <= 1'b0;
            id_exit_pulse    <= 1'b0;
        end else begin
            prog_pulse       <= cmd.prog;
            chip_erase_pulse <= cmd.chip;
            sect_erase_pulse <= cmd.sect;
            boot_lock_pulse  <= cmd.lock;
            id_enter_pulse   <= cmd.id_in;
            id_exit_pulse    <= cmd.id_out;
        end
    end

    // Payload registers, loaded only with their command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr <= '0;
            prog_data <= '0;
            sect_addr <= '0;
        end else begin
            if (cmd.prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (cmd.sect) sect_addr <= wr_addr;
        end
    end

    // R1: nothing is issued in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !(prog_pulse | chip_erase_pulse | sect_erase_pulse |
                             boot_lock_pulse | id_enter_pulse | id_exit_pulse));

    // R11: never more than one command at once.
    a_r11_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_pulse, chip_erase_pulse, sect_erase_pulse,
                  boot_lock_pulse, id_enter_pulse, id_exit_pulse}));

    // R3: program payload equals the preceding strobed write.
    a_r3_prog_payload: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> ($past(wr_stb) && prog_addr == $past(wr_addr) &&
                        prog_data == $past(wr_data)));

    // R6: chip erase follows a 10h write at the first key address.
    a_r6_chip_code: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_pulse |-> ($past(wr_data) == OP_CHIP &&
                              $past(wr_addr[CMP_W-1:0]) == ADR_KEY_A));

    // R7: sector erase carries the address of a 30h write.
    a_r7_sect_payload: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_pulse |-> ($past(wr_data) == OP_SECT &&
                              sect_addr == $past(wr_addr)));

    // R8: boot lockout follows a 40h write.
    a_r8_lock_code: assert property (@(posedge clk) disable iff (!rst_n)
        boot_lock_pulse |-> $past(wr_data) == OP_LOCK);

    // R10: a busy cycle issues no command.
    a_r10_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !(prog_pulse | chip_erase_pulse | sect_erase_pulse |
                          boot_lock_pulse | id_enter_pulse | id_exit_pulse));

endmodule

// File: tb/fcmd_decoder_test.sv
// Scoreboard bench: stimulus pushes expected pulses into a queue, a monitor
// pops and compares them whenever the decoder emits one.
module fcmd_decoder_test;

    localparam int AW = 20;
    localparam int K_PROG = 0, K_CHIP = 1, K_SECT = 2, K_LOCK = 3, K_IDIN = 4, K_IDOUT = 5;

    typedef struct {
        int           kind;
        logic [AW-1:0] addr;
        logic [7:0]   data;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0;
    logic wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic prog_pulse, chip_erase_pulse, sect_erase_pulse, boot_lock_pulse;
    logic id_enter_pulse, id_exit_pulse, id_mode;
    logic [AW-1:0] prog_addr, sect_addr;
    logic [7:0] prog_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R1";
    exp_t exp_q[$];

    always #2 clk = ~clk;

    fcmd_decoder #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_pulse(prog_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_pulse(chip_erase_pulse), .sect_erase_pulse(sect_erase_pulse),
        .sect_addr(sect_addr), .boot_lock_pulse(boot_lock_pulse),
        .id_enter_pulse(id_enter_pulse), .id_exit_pulse(id_exit_pulse),
        .id_mode(id_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic expect_cmd(input int k, input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic key();
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every emitted pulse with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n;
            int k;
            n = int'(prog_pulse) + int'(chip_erase_pulse) + int'(sect_erase_pulse) +
                int'(boot_lock_pulse) + int'(id_enter_pulse) + int'(id_exit_pulse);
            k = prog_pulse ? K_PROG : chip_erase_pulse ? K_CHIP : sect_erase_pulse ? K_SECT :
                boot_lock_pulse ? K_LOCK : id_enter_pulse ? K_IDIN : K_IDOUT;
            if (n > 1) check("R11 pulses per cycle", n, 1);
            if (n >= 1) begin
                if (exp_q.size() == 0) begin
                    check({cur_tag, " unexpected pulse kind"}, k, 32'hFFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " pulse kind"}, k, e.kind);
                    if (e.kind == K_PROG) begin
                        check({e.tag, " prog_addr"}, prog_addr, e.addr);
                        check({e.tag, " prog_data"}, prog_data, e.data);
                    end
                    if (e.kind == K_SECT) check({e.tag, " sect_addr"}, sect_addr, e.addr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 id_mode", id_mode, 0);
        check("R1 pulses", {prog_pulse, chip_erase_pulse, sect_erase_pulse,
                            boot_lock_pulse, id_enter_pulse, id_exit_pulse}, 0);

        // R3: byte program
        cur_tag = "R3";
        expect_cmd(K_PROG, 20'h12345, 8'h3C, "R3");
        key(); wr(20'h05555, 8'hA0); wr(20'h12345, 8'h3C);
        idle(2);

        // R2: upper address bits ignored in key and opcode writes
        cur_tag = "R2";
        expect_cmd(K_PROG, 20'hABCDE, 8'h5A, "R2");
        wr(20'hF5555, 8'hAA); wr(20'hA2AAA, 8'h55); wr(20'h35555, 8'hA0); wr(20'hABCDE, 8'h5A);
        idle(2);

        // R4: identification entry
        cur_tag = "R4";
        expect_cmd(K_IDIN, '0, '0, "R4");
        key(); wr(20'h05555, 8'h90);
        check("R4 id_mode set", id_mode, 1);

        // R9: F0h inside a broken key is not an exit
        cur_tag = "R9";
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'hF0);
        idle(2);
        check("R9 id_mode kept", id_mode, 1);

        // R5: exit via keyed F0h
        cur_tag = "R5";
        expect_cmd(K_IDOUT, '0, '0, "R5");
        key(); wr(20'h05555, 8'hF0);
        check("R5 keyed exit", id_mode, 0);

        // R5: lone F0h at arbitrary address
        expect_cmd(K_IDIN, '0, '0, "R5");
        key(); wr(20'h05555, 8'h90);
        expect_cmd(K_IDOUT, '0, '0, "R5");
        wr(20'h00777, 8'hF0);
        check("R5 lone exit", id_mode, 0);

        // R6, R7, R8: six-write family
        cur_tag = "R6";
        expect_cmd(K_CHIP, '0, '0, "R6");
        key(); wr(20'h05555, 8'h80); key(); wr(20'h05555, 8'h10);
        idle(2);
        cur_tag = "R7";
        expect_cmd(K_SECT, 20'h9A123, '0, "R7");
        key(); wr(20'h05555, 8'h80); key(); wr(20'h9A123, 8'h30);
        idle(2);
        cur_tag = "R8";
        expect_cmd(K_LOCK, '0, '0, "R8");
        key(); wr(20'h05555, 8'h80); key(); wr(20'h05555, 8'h40);
        idle(2);

        // R9: mismatches return to idle without command
        cur_tag = "R9";
        wr(20'h05555, 8'hAA); wr(20'h02AAB, 8'h55); wr(20'h05555, 8'hA0); wr(20'h01000, 8'h11);
        key(); wr(20'h05555, 8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h54); wr(20'h05555, 8'h10);
        key(); wr(20'h05555, 8'h80); key(); wr(20'h05555, 8'h20);
        key(); wr(20'h05555, 8'h80); key(); wr(20'h05554, 8'h10);
        idle(2);
        expect_cmd(K_PROG, 20'h00042, 8'h00, "R9");
        key(); wr(20'h05555, 8'hA0); wr(20'h00042, 8'h00);
        idle(2);

        // R10: busy blocks and aborts
        cur_tag = "R10";
        busy = 1'b1;
        key(); wr(20'h05555, 8'hA0); wr(20'h00100, 8'h77);
        key(); wr(20'h05555, 8'h90);
        busy = 1'b0;
        idle(2);
        check("R10 id_mode unchanged", id_mode, 0);
        key();
        busy = 1'b1; idle(1); busy = 1'b0;
        wr(20'h05555, 8'hA0); wr(20'h00200, 8'h66);
        idle(2);

        // R1: reset mid-sequence clears state and flag
        cur_tag = "R1";
        expect_cmd(K_IDIN, '0, '0, "R1");
        key(); wr(20'h05555, 8'h90);
        key();
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        check("R1 id_mode after reset", id_mode, 0);
        wr(20'h05555, 8'hA0); wr(20'h00300, 8'h55);
        idle(3);

        // R11: every expected pulse was seen exactly once
        check("R11 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule